// File: doc/BRIEF.md
# Threshold-Triggered Transmit Frame FIFO

This block collects an outgoing Ethernet frame one 32-bit word at a time and hands it to a byte-serial transmitter. Each word written on the data port is unpacked least significant byte first into a word-organised buffer. The first word of a frame carries, in its low 16 bits, the number of payload bytes that follow the 14-byte header. Those two length bytes are kept in the buffer but are never emitted.

A frame leaves the buffer in one of two ways. It can go automatically, right after a data write, when a programmable fill threshold is armed and reached and the stored bytes cover the whole frame. It can also go when the host raises the transmit request. While a frame streams out, further data writes are dropped. When the last byte is taken, the buffer empties and a transmit-empty flag is raised. A length word that is too large is refused and raises a transmit-error flag. Acknowledging that flag also discards whatever had been buffered.

Top module: `txq_frame_fifo`

## Requirements
- R1: When the buffer is empty, a data word whose low 16 bits exceed 2032 is refused. No byte is stored, and the error flag `st_err` (status bit 1) is set.
- R2: An accepted word is stored as four bytes, bits [7:0] at the lowest buffer address. A word is stored only while the fill count is at most 2044 bytes, so the count never passes 2048. A word arriving when the buffer is full is lost.
- R3: A frame is complete once the fill count is at least the data length plus 16. When the automatic-checksum control bit (`ctl_wdata` bit 2) is clear, 4 further bytes are needed. The requirement is capped at 2048 bytes.
- R4: The threshold is armed only while the 6-bit threshold value is below 63. It is met when the fill count is at least 32*threshold + 4. Right after a data write, the frame starts streaming if the threshold is armed and met and the frame is complete; otherwise no output appears.
- R5: After reset, the threshold is 63 (automatic sending off), the buffer is empty, both control bits are clear, both status flags are low and `out_valid` is low.
- R6: A pulse on `xmit_req` while the buffer holds data starts a send, whether or not the frame is complete. Bytes beyond the written ones come from whatever the buffer last held at those addresses.
- R7: The emitted byte count is the data length plus 14, starting at buffer byte 2. If the pad control bit (`ctl_wdata` bit 1) is set and this count is below 60, zero bytes are appended up to 60. Any byte at or beyond position data-length+14 of the emitted frame is zero.
- R8: On the cycle after the last byte is accepted, `out_valid` is low, the buffer is empty and `st_empty` (status bit 2) is high. An acknowledge with bit 2 set clears `st_empty`. An acknowledge with bit 1 set clears `st_err` and empties the buffer.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. `out_last` marks the final byte of each frame.
- R10: Data writes made while a frame is streaming are ignored. They change neither the fill count nor the bytes still to be emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word; low 16 bits are the length when the buffer is empty |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit 1 pad enable, bit 2 automatic checksum |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 6 | Threshold value; 63 disables automatic sending |
| xmit_req | input | 1 | Transmit request pulse |
| ack_we | input | 1 | Status acknowledge strobe |
| ack_wdata | input | 3 | Bit 1 clears error and buffer, bit 2 clears empty flag |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | A frame byte is presented |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| st_err | output | 1 | Transmit error flag |
| st_empty | output | 1 | Transmit empty flag |

## Verification
The bound checker watches, on every cycle, that the output handshake holds steady under back-pressure and that the fill count stays word-aligned and bounded. It also checks that a finished frame leaves the buffer empty with the empty flag raised, that an oversized first length is refused, that writes during streaming leave the count untouched, and that nothing starts on its own while the threshold is disarmed.

Only the bench scenarios can show the byte contents of a frame: little-endian unpacking, the start at buffer byte 2, zero padding, stale bytes sent on a forced request, and that ignored writes do not corrupt the bytes still queued. The same holds for the exact write on which a threshold frame launches, and for the 2048-byte caps on both completion and storage.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int CTL_PAD_BIT  = 1;
    localparam int CTL_CRC_BIT  = 2;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_EMPTY_BIT = 2;
    localparam int PREFIX_BYTES = 2;
    localparam int FCS_BYTES    = 4;
    localparam int WORD_BYTES   = 4;

    typedef struct packed {
        logic crc_auto;
        logic pad_en;
    } txq_ctl_t;

    // bytes the buffer must hold before the frame counts as complete
    function automatic int unsigned need_bytes(input int unsigned dlen,
                                               input logic        crc_auto,
                                               input int unsigned hdr,
                                               input int unsigned cap);
        int unsigned r;
        r = dlen + hdr + PREFIX_BYTES + (crc_auto ? 0 : FCS_BYTES);
        return (r > cap) ? cap : r;
    endfunction

    // fill level at which an armed threshold is met
    function automatic int unsigned thr_bytes(input int unsigned thr);
        return WORD_BYTES * (thr * 8 + 1);
    endfunction

    // unpadded frame length, capped to what the buffer can hold after the prefix
    function automatic int unsigned body_bytes(input int unsigned dlen,
                                               input int unsigned hdr,
                                               input int unsigned cap);
        int unsigned r;
        r = dlen + hdr;
        return (r > cap) ? cap : r;
    endfunction

    // emitted length including padding to the minimum size
    function automatic int unsigned emit_bytes(input int unsigned dlen,
                                               input logic        pad_en,
                                               input int unsigned hdr,
                                               input int unsigned min_len,
                                               input int unsigned cap);
        int unsigned r;
        r = dlen + hdr;
        if (pad_en && r < min_len) r = min_len;
        return (r > cap) ? cap : r;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store import txq_pkg::*; #(
    parameter int BUF_BYTES = 2048,
    parameter int CNT_W     = 12,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [31:0]      push_word,
    input  logic             clr,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt,
    output logic [LEN_W-1:0] dlen,
    output logic [7:0]       rd_byte
);
    localparam int WORDS = BUF_BYTES / WORD_BYTES;
    localparam int AW    = $clog2(WORDS);

    logic [31:0]      mem_q [WORDS];
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] dlen_q;
    logic [31:0]      rd_word;
    logic [7:0]       lane [WORD_BYTES];
    logic             unused_hi;

    always_ff @(posedge clk) begin
        if (push) mem_q[cnt_q[AW+1:2]] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + CNT_W'(WORD_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlen_q <= '0;
        end else if (push && cnt_q == '0) begin
            dlen_q <= push_word[LEN_W-1:0];
        end
    end

    assign rd_word = mem_q[rd_idx[AW+1:2]];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane[g] = rd_word[8*g +: 8];
    end

    assign rd_byte   = lane[rd_idx[1:0]];
    assign cnt       = cnt_q;
    assign dlen      = dlen_q;
    assign unused_hi = ^rd_idx[CNT_W-1:AW+2];

endmodule

// File: rtl/txq_regs.sv
module txq_regs import txq_pkg::*; #(
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             ack_we,
    input  logic [2:0]       ack_wdata,
    input  logic             set_err,
    input  logic             set_empty,
    output txq_ctl_t         ctl,
    output logic [THR_W-1:0] thr,
    output logic             st_err,
    output logic             st_empty,
    output logic             clr_err_req
);
    txq_ctl_t         ctl_q;
    logic [THR_W-1:0] thr_q;
    logic             err_q, empty_q;
    logic             clr_empty;
    logic             unused_bits;

    assign clr_err_req = ack_we && ack_wdata[ST_ERR_BIT];
    assign clr_empty   = ack_we && ack_wdata[ST_EMPTY_BIT];
    assign unused_bits = ctl_wdata[0] ^ ack_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            thr_q <= '1;
        end else begin
            if (ctl_we) begin
                ctl_q.pad_en   <= ctl_wdata[CTL_PAD_BIT];
                ctl_q.crc_auto <= ctl_wdata[CTL_CRC_BIT];
            end
            if (thr_we) thr_q <= thr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            if (set_err)          err_q <= 1'b1;
            else if (clr_err_req) err_q <= 1'b0;
            if (set_empty)        empty_q <= 1'b1;
            else if (clr_empty)   empty_q <= 1'b0;
        end
    end

    assign ctl      = ctl_q;
    assign thr      = thr_q;
    assign st_err   = err_q;
    assign st_empty = empty_q;

endmodule

// File: rtl/txq_stream.sv
module txq_stream import txq_pkg::*; #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] emit_len,
    input  logic [CNT_W-1:0] body_len,
    input  logic             out_ready,
    output logic             busy,
    output logic             last,
    output logic             pad_zone,
    output logic             done,
    output logic [CNT_W-1:0] rd_idx
);
    logic             busy_q;
    logic [CNT_W-1:0] pos_q, len_q, body_q;

    assign busy     = busy_q;
    assign last     = busy_q && (pos_q == len_q - CNT_W'(1));
    assign pad_zone = pos_q >= body_q;
    assign done     = busy_q && out_ready && last;
    assign rd_idx   = pos_q + CNT_W'(PREFIX_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            len_q  <= '0;
            body_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                len_q  <= emit_len;
                body_q <= body_len;
            end
        end else if (out_ready) begin
            if (last) begin
                busy_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q <= pos_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/txq_frame_fifo.sv
module txq_frame_fifo import txq_pkg::*; #(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_DATA  = 2032,
    parameter int HDR_BYTES = 14,
    parameter int MIN_FRAME = 60,
    parameter int THR_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             xmit_req,
    input  logic             ack_we,
    input  logic [2:0]       ack_wdata,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             st_err,
    output logic             st_empty
);
    localparam int CNT_W   = $clog2(BUF_BYTES + 1);
    localparam int LEN_W   = 16;
    localparam int SEND_CAP = BUF_BYTES - PREFIX_BYTES;

    txq_ctl_t         ctl;
    logic [THR_W-1:0] thr_q;
    logic             clr_err_req;
    logic             busy, done, pad_zone;
    logic [CNT_W-1:0] fill_cnt, rd_idx, cnt_after, emit_len, body_len;
    logic [LEN_W-1:0] dlen_q, dlen_nx, len_in;
    logic [7:0]       rd_byte;
    logic             wr_ok, is_first, reject, has_room, push, buf_clr;
    logic             thr_hit, full_hit, auto_go, kick_go, start;

    assign len_in   = wr_data[LEN_W-1:0];
    assign wr_ok    = wr_valid && !busy;
    assign is_first = (fill_cnt == '0);
    assign reject   = wr_ok && is_first && (32'(len_in) > 32'(MAX_DATA));
    assign has_room = 32'(fill_cnt) <= 32'(BUF_BYTES - WORD_BYTES);
    assign push     = wr_ok && !reject && has_room;
    assign buf_clr  = done || (clr_err_req && !busy);

    assign cnt_after = fill_cnt + (push ? CNT_W'(WORD_BYTES) : CNT_W'(0));
    assign dlen_nx   = (push && is_first) ? len_in : dlen_q;

    assign thr_hit  = (thr_q != '1) &&
                      (32'(cnt_after) >= thr_bytes(32'(thr_q)));
    assign full_hit = 32'(cnt_after) >=
                      need_bytes(32'(dlen_nx), ctl.crc_auto, HDR_BYTES, BUF_BYTES);
    assign auto_go  = wr_ok && !reject && thr_hit && full_hit && !clr_err_req;
    assign kick_go  = xmit_req && !busy && (cnt_after != '0) && !clr_err_req;
    assign start    = auto_go || kick_go;

    assign emit_len = CNT_W'(emit_bytes(32'(dlen_nx), ctl.pad_en, HDR_BYTES,
                                        MIN_FRAME, SEND_CAP));
    assign body_len = CNT_W'(body_bytes(32'(dlen_nx), HDR_BYTES, SEND_CAP));

    txq_regs #(.THR_W(THR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .thr_we     (thr_we),
        .thr_wdata  (thr_wdata),
        .ack_we     (ack_we),
        .ack_wdata  (ack_wdata),
        .set_err    (reject),
        .set_empty  (done),
        .ctl        (ctl),
        .thr        (thr_q),
        .st_err     (st_err),
        .st_empty   (st_empty),
        .clr_err_req(clr_err_req)
    );

    txq_store #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_word(wr_data),
        .clr      (buf_clr),
        .rd_idx   (rd_idx),
        .cnt      (fill_cnt),
        .dlen     (dlen_q),
        .rd_byte  (rd_byte)
    );

    txq_stream #(.CNT_W(CNT_W)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .emit_len (emit_len),
        .body_len (body_len),
        .out_ready(out_ready),
        .busy     (busy),
        .last     (out_last),
        .pad_zone (pad_zone),
        .done     (done),
        .rd_idx   (rd_idx)
    );

    assign out_valid = busy;
    assign out_data  = pad_zone ? 8'h00 : rd_byte;

endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_DATA  = 2032,
    parameter int THR_W     = 6,
    parameter int CNT_W     = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic [15:0]      wr_len,
    input logic             xmit_req,
    input logic             ack_we,
    input logic             out_ready,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             st_err,
    input logic             st_empty,
    input logic [CNT_W-1:0] cnt,
    input logic [THR_W-1:0] thr
);

    a_r1_refuse_long: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !out_valid && cnt == '0 && 32'(wr_len) > 32'(MAX_DATA) && !ack_we)
        |=> (st_err && cnt == '0));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt) <= 32'(BUF_BYTES)) && (cnt[1:0] == 2'b00));

    a_r4_no_auto_when_off: assert property (@(posedge clk) disable iff (rst)
        (thr == '1 && !xmit_req && !out_valid) |=> !out_valid);

    a_r8_finish_state: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && st_empty && cnt == '0));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wr_valid && !(out_ready && out_last)) |=> $stable(cnt));

endmodule

bind txq_frame_fifo txq_checker #(
    .BUF_BYTES(BUF_BYTES),
    .MAX_DATA (MAX_DATA),
    .THR_W    (THR_W),
    .CNT_W    (CNT_W)
) u_txq_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_len   (wr_data[15:0]),
    .xmit_req (xmit_req),
    .ack_we   (ack_we),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .st_err   (st_err),
    .st_empty (st_empty),
    .cnt      (fill_cnt),
    .thr      (thr_q)
);

// File: tb/test_txq_frame_fifo.sv
`timescale 1ns/1ps
module test_txq_frame_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic        thr_we = 1'b0;
    logic [5:0]  thr_wdata = '0;
    logic        xmit_req = 1'b0;
    logic        ack_we = 1'b0;
    logic [2:0]  ack_wdata = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_last, st_err, st_empty;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    txq_frame_fifo i_txq_frame_fifo (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .xmit_req(xmit_req), .ack_we(ack_we), .ack_wdata(ack_wdata),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .st_err(st_err), .st_empty(st_empty)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;
    bit stall_en = 1'b0;

    // reference model
    logic [7:0] mm [2048];
    int m_cnt = 0, m_dlen = 0, m_thr = 63;
    bit m_pad = 1'b0, m_crc = 1'b0;
    logic [8:0] exp_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int need();
        int r;
        r = m_dlen + 16 + (m_crc ? 0 : 4);
        return (r > 2048) ? 2048 : r;
    endfunction

    task automatic push_frame();
        int body, emit;
        body = m_dlen + 14;
        emit = (m_pad && body < 60) ? 60 : body;
        if (emit > 2046) emit = 2046;
        for (int k = 0; k < emit; k++)
            exp_q.push_back({k == emit - 1, (k >= body) ? 8'h00 : mm[k + 2]});
        m_cnt = 0;
    endtask

    task automatic model_write(input logic [31:0] w);
        if (m_cnt == 0 && w[15:0] > 16'd2032) return;
        if (m_cnt <= 2044) begin
            if (m_cnt == 0) m_dlen = int'(w[15:0]);
            for (int b = 0; b < 4; b++) mm[m_cnt + b] = w[8*b +: 8];
            m_cnt += 4;
        end
        if (m_thr < 63 && m_cnt >= 32 * m_thr + 4 && m_cnt >= need()) push_frame();
    endtask

    task automatic wr_word(input logic [31:0] w, input bit ignored);
        @(posedge clk); #1; wr_valid = 1'b1; wr_data = w;
        @(posedge clk); #1; wr_valid = 1'b0;
        if (!ignored) model_write(w);
    endtask

    function automatic logic [31:0] wd(input int seed, input int i);
        return {8'(seed), 8'(i), 8'(i * 3 + seed), 8'(i * 7 + 1)};
    endfunction

    task automatic kick();
        @(posedge clk); #1; xmit_req = 1'b1;
        @(posedge clk); #1; xmit_req = 1'b0;
        if (m_cnt != 0) push_frame();
    endtask

    task automatic set_ctl(input bit pad, input bit crc);
        @(posedge clk); #1; ctl_we = 1'b1; ctl_wdata = {crc, pad, 1'b0};
        @(posedge clk); #1; ctl_we = 1'b0;
        m_pad = pad; m_crc = crc;
    endtask

    task automatic set_thr(input int t);
        @(posedge clk); #1; thr_we = 1'b1; thr_wdata = 6'(t);
        @(posedge clk); #1; thr_we = 1'b0;
        m_thr = t;
    endtask

    task automatic ack(input logic [2:0] bits);
        @(posedge clk); #1; ack_we = 1'b1; ack_wdata = bits;
        @(posedge clk); #1; ack_we = 1'b0;
        if (bits[1]) m_cnt = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || out_valid);
    endtask

    // back-pressure pattern
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
        end
    end

    // scoreboard monitor (R9 hold + byte compare)
    initial begin
        bit hold_pend = 1'b0;
        logic [8:0] hold_v = '0;
        forever begin
            @(negedge clk);
            if (hold_pend) begin
                check(out_valid && {out_last, out_data} == hold_v, "R9 hold",
                      int'({out_valid, out_last, out_data}), int'({1'b1, hold_v}));
                hold_pend = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected byte", int'(out_data), -1);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({out_last, out_data} == e, "R7 byte",
                          int'({out_last, out_data}), int'(e));
                end
            end else if (out_valid) begin
                hold_pend = 1'b1;
                hold_v = {out_last, out_data};
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check(!out_valid, "R5 out_valid", int'(out_valid), 0);
        check(!st_err && !st_empty, "R5 status", int'({st_err, st_empty}), 0);

        // R4 + R6: threshold off, frame complete but idle until request
        wr_word({16'h5A00, 16'd4}, 0);
        for (int i = 1; i < 6; i++) wr_word(wd(1, i), 0);
        repeat (3) @(negedge clk);
        check(!out_valid, "R4 no auto send at thr 63", int'(out_valid), 0);
        kick();
        wait_idle();
        check(st_empty, "R8 empty flag after send", int'(st_empty), 1);
        ack(3'b100);
        @(negedge clk);
        check(!st_empty, "R8 empty flag cleared", int'(st_empty), 0);

        // R3 + R7: threshold 0, pad on, auto checksum on
        set_ctl(1'b1, 1'b1);
        set_thr(0);
        wr_word({16'h1234, 16'd10}, 0);
        for (int i = 1; i < 6; i++) wr_word(wd(2, i), 0);
        check(!out_valid, "R3 incomplete frame held", int'(out_valid), 0);
        wr_word(wd(2, 6), 0);
        check(out_valid, "R3 send on completing write", int'(out_valid), 1);
        wait_idle();

        // R4 + R9: threshold 2 (68 bytes) dominates completion, with back-pressure
        set_ctl(1'b0, 1'b1);
        set_thr(2);
        wr_word({16'h0077, 16'd30}, 0);
        for (int i = 1; i < 16; i++) wr_word(wd(3, i), 0);
        check(!out_valid, "R4 below threshold", int'(out_valid), 0);
        stall_en = 1'b1;
        wr_word(wd(3, 16), 0);
        check(out_valid, "R4 threshold reached", int'(out_valid), 1);
        wait_idle();

        // R6 + R10: forced send of short-filled frame, write during streaming
        set_thr(63);
        wr_word({16'h00AA, 16'd40}, 0);
        for (int i = 1; i < 4; i++) wr_word(wd(4, i), 0);
        kick();
        do @(negedge clk); while (exp_q.size() > 30);
        wr_word(32'hDEADBEEF, 1);
        wr_word(32'h0000FFFF, 1);
        wait_idle();
        check(!st_err, "R10 no error from ignored write", int'(st_err), 0);
        stall_en = 1'b0;

        // R1 + R8: oversized length, error acknowledge clears buffer
        wr_word({16'h0000, 16'd2033}, 0);
        @(negedge clk);
        check(st_err, "R1 error flag", int'(st_err), 1);
        check(!out_valid, "R1 nothing sent", int'(out_valid), 0);
        wr_word({16'h0000, 16'd8}, 0);
        wr_word(wd(5, 1), 0);
        ack(3'b010);
        @(negedge clk);
        check(!st_err, "R8 error cleared", int'(st_err), 0);
        set_thr(0);
        wr_word({16'h4321, 16'd0}, 0);
        for (int i = 1; i < 3; i++) wr_word(wd(6, i), 0);
        check(!out_valid, "R8 buffer restarted empty", int'(out_valid), 0);
        wr_word(wd(6, 3), 0);
        check(out_valid, "R1 fresh frame sent", int'(out_valid), 1);
        wait_idle();

        // R2: full buffer, extra word lost, forced send of 2046 bytes
        set_ctl(1'b0, 1'b0);
        set_thr(63);
        wr_word({16'hBEEF, 16'd2032}, 0);
        for (int i = 1; i < 513; i++) wr_word(wd(7, i), 0);
        check(!out_valid, "R2 full buffer idle", int'(out_valid), 0);
        kick();
        wait_idle();

        // R3 cap: completion limited to 2048 bytes
        set_thr(0);
        wr_word({16'h0101, 16'd2032}, 0);
        for (int i = 1; i < 511; i++) wr_word(wd(8, i), 0);
        check(!out_valid, "R3 511 words not complete", int'(out_valid), 0);
        wr_word(wd(8, 511), 0);
        check(out_valid, "R3 capped completion", int'(out_valid), 1);
        wait_idle();
        check(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end

endmodule